// File: doc/BRIEF.md
# VFD Grid Scanner with Dimming

This block drives the time-multiplexed grid and segment enables of a vacuum-fluorescent display with 8 to 16 digits of 24 segments each. It steps through the enabled digits in order and gives each digit a fixed time slot. During a slot it drives one grid line and the 24 segment lines of that digit. The segment pattern comes from three consecutive bytes of display RAM. Each slot is split into 16 equal subslots. The outputs stay active only for the first N subslots, where N comes from a nonlinear dimming code.

The command decoder upstream passes two kinds of single-cycle writes into the block. A mode write selects the digit count. A control write sets the on/off flag and the dimming code. A mode write that actually changes the digit count forces the display dark until the next control write turns it back on. The block reads the display RAM through a synchronous read port with one cycle of latency. It fetches the three bytes for the next digit while the current digit is on screen, so that every slot opens with settled data. A one-cycle frame-end strobe marks the last clock of each frame, for the key-scan logic. Scanning runs whether the display is lit or dark.

Top module: `vfd_grid_scanner`

## Requirements
- R1: After reset the display is dark (all grid and segment outputs 0), 16 digits are enabled and the dimming code is 000.
- R2: On a mode write, code 0000 selects 8 digits and code 1ttt selects 9+t digits. Any other code (0001 to 0111) leaves the mode and the on/off flag unchanged.
- R3: A mode write whose digit count differs from the current one turns the display off from the next clock onward. A mode write of the current digit count changes nothing.
- R4: On a control write, bit 3 sets the display on (1) or off (0). Bits 2..0 select the lit width: 000..111 give 1, 2, 4, 10, 11, 12, 13 and 14 subslots out of 16.
- R5: A slot lasts 16 subslots of SUB_CYC clocks each. Slot n (digit n+1) raises only grid_out[n], and only during its first N subslots. Slots run from 0 up to the last enabled digit and then wrap to 0.
- R6: While grid_out[n] is high, seg_out[7:0], seg_out[15:8] and seg_out[23:16] equal the RAM bytes at addresses 3n, 3n+1 and 3n+2. At all other times seg_out is 0.
- R7: While the display is off, grid_out and seg_out stay 0. Slot timing and frame_end continue unchanged.
- R8: frame_end is high for exactly one clock, the last clock of the last enabled slot, and is low at all other times.
- R9: If a mode write with a changed digit count and a control write with bit 3 set arrive in the same clock, the display ends up off.
- R10: The block only reads RAM addresses 0 to 47 (decimal).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Single-cycle strobe for a mode write |
| mode_code | input | 4 | Mode code for the digit count |
| ctrl_wr | input | 1 | Single-cycle strobe for a control write |
| ctrl_code | input | 4 | Bit 3 display on, bits 2..0 dimming code |
| ram_rd_en | output | 1 | RAM read enable |
| ram_rd_addr | output | 6 | RAM byte address |
| ram_rd_data | input | 8 | RAM read data, valid one clock after the enable |
| grid_out | output | 16 | Grid enables, bit n for digit n+1 |
| seg_out | output | 24 | Segment enables |
| frame_end | output | 1 | High in the last clock of each frame |

## Verification
The bench compares every clock of a full frame against a cycle-exact expected grid, segment and frame-end pattern. This is done for all eight dimming codes, for the 8-, 12- and 16-digit modes, and with the display lit and dark. The width sweep separates the nonlinear table from a linear or power-of-two guess. Mode and control sequences check four cases apart: a changed mode, an identical mode, an invalid code, and a mode change and control write in the same clock. The RAM contents are reloaded with a different pattern between scenarios, which shows that segments follow the memory and not stale shadow data.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;
  localparam int GRIDS     = 16;
  localparam int SUBS      = 16;
  localparam int SEG_BYTES = 3;
  localparam int SEG_W     = 8 * SEG_BYTES;
  localparam int RAM_DEPTH = GRIDS * SEG_BYTES;

  // lit width in subslots for a dimming code
  function automatic logic [4:0] dim_width(input logic [2:0] code);
    case (code)
      3'd0: return 5'd1;
      3'd1: return 5'd2;
      3'd2: return 5'd4;
      3'd3: return 5'd10;
      3'd4: return 5'd11;
      3'd5: return 5'd12;
      3'd6: return 5'd13;
      default: return 5'd14;
    endcase
  endfunction

  function automatic logic mode_valid(input logic [3:0] code);
    return (code == 4'd0) || code[3];
  endfunction

  // index of the last enabled slot
  function automatic logic [3:0] mode_last(input logic [3:0] code);
    return code[3] ? (4'd8 + {1'b0, code[2:0]}) : 4'd7;
  endfunction

  function automatic logic [5:0] digit_base(input logic [3:0] slot);
    return 6'(slot) * 6'(SEG_BYTES);
  endfunction
endpackage

// File: rtl/vfd_ctrl_regs.sv
module vfd_ctrl_regs
  import vfd_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [3:0] mode_code,
  input  logic       ctrl_wr,
  input  logic [3:0] ctrl_code,
  output logic [3:0] last_idx,
  output logic [2:0] dim_code,
  output logic       disp_on,
  output logic       mode_changed
);
  assign mode_changed = mode_wr && mode_valid(mode_code) &&
                        (mode_last(mode_code) != last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_idx <= 4'd15;
      dim_code <= 3'd0;
      disp_on  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        disp_on  <= ctrl_code[3];
        dim_code <= ctrl_code[2:0];
      end
      if (mode_changed) begin
        last_idx <= mode_last(mode_code);
        disp_on  <= 1'b0;
      end
    end
  end

  // R3 R9
  property mode_forces_off;
    @(posedge clk) disable iff (!rst_n) mode_changed |=> !disp_on;
  endproperty
  mode_off_chk: assert property (mode_forces_off);

  // R2
  property bad_code_keeps_mode;
    @(posedge clk) disable iff (!rst_n)
      (mode_wr && !mode_valid(mode_code) && !ctrl_wr) |=> ($stable(last_idx) && $stable(disp_on));
  endproperty
  bad_mode_chk: assert property (bad_code_keeps_mode);
endmodule

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer
  import vfd_scan_pkg::*;
#(
  parameter int SUB_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] last_idx,
  output logic [3:0] slot,
  output logic [3:0] sub,
  output logic [3:0] nxt_slot,
  output logic       slot_end,
  output logic       slot_start,
  output logic       frame_end
);
  localparam int PW = (SUB_CYC > 1) ? $clog2(SUB_CYC) : 1;

  logic [PW-1:0] pre;
  logic          pre_last;

  assign pre_last  = (pre == PW'(SUB_CYC - 1));
  assign slot_end  = pre_last && (sub == 4'(SUBS - 1));
  assign frame_end = slot_end && (slot >= last_idx);
  assign nxt_slot  = (slot >= last_idx) ? 4'd0 : slot + 4'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre        <= '0;
      sub        <= '0;
      slot       <= '0;
      slot_start <= 1'b1;
    end else begin
      pre        <= pre_last ? '0 : pre + 1'b1;
      slot_start <= slot_end;
      if (pre_last) sub <= sub + 4'd1;
      if (slot_end) slot <= nxt_slot;
    end
  end

  // R8
  property wrap_after_frame;
    @(posedge clk) disable iff (!rst_n) frame_end |=> (slot == 4'd0 && sub == 4'd0);
  endproperty
  frame_wrap_chk: assert property (wrap_after_frame);

  // R5
  property slot_holds;
    @(posedge clk) disable iff (!rst_n) !$past(slot_end) |-> $stable(slot);
  endproperty
  slot_hold_chk: assert property (slot_holds);
endmodule

// File: rtl/vfd_seg_fetch.sv
module vfd_seg_fetch
  import vfd_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_start,
  input  logic             slot_end,
  input  logic [3:0]       nxt_slot,
  input  logic [7:0]       rd_data,
  output logic             rd_en,
  output logic [5:0]       rd_addr,
  output logic [SEG_W-1:0] seg_cur
);
  logic [5:0] base_q;
  logic [1:0] fidx;
  logic       fbusy;
  logic       cap_q;
  logic [1:0] cap_idx;
  logic [7:0] shadow [SEG_BYTES];

  assign rd_en   = fbusy;
  assign rd_addr = base_q + 6'(fidx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      fidx    <= '0;
      fbusy   <= 1'b0;
      cap_q   <= 1'b0;
      cap_idx <= '0;
    end else begin
      cap_q   <= rd_en;
      cap_idx <= fidx;
      if (slot_start) begin
        base_q <= digit_base(nxt_slot);
        fidx   <= '0;
        fbusy  <= 1'b1;
      end else if (fbusy) begin
        fidx  <= fidx + 2'd1;
        fbusy <= (fidx != 2'(SEG_BYTES - 1));
      end
    end
  end

  for (genvar b = 0; b < SEG_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow[b]          <= '0;
        seg_cur[8*b +: 8]  <= '0;
      end else begin
        if (cap_q && cap_idx == 2'(b)) shadow[b] <= rd_data;
        if (slot_end) seg_cur[8*b +: 8] <= shadow[b];
      end
    end
  end

  // R10
  property addr_in_range;
    @(posedge clk) disable iff (!rst_n) rd_en |-> (rd_addr < 6'(RAM_DEPTH));
  endproperty
  addr_range_chk: assert property (addr_in_range);
endmodule

// File: rtl/vfd_grid_scanner.sv
module vfd_grid_scanner
  import vfd_scan_pkg::*;
#(
  parameter int SUB_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_wr,
  input  logic [3:0]  mode_code,
  input  logic        ctrl_wr,
  input  logic [3:0]  ctrl_code,
  output logic        ram_rd_en,
  output logic [5:0]  ram_rd_addr,
  input  logic [7:0]  ram_rd_data,
  output logic [15:0] grid_out,
  output logic [23:0] seg_out,
  output logic        frame_end
);
  logic [3:0]       last_idx;
  logic [2:0]       dim_code;
  logic             disp_on;
  logic             mode_changed;
  logic [3:0]       slot;
  logic [3:0]       sub;
  logic [3:0]       nxt_slot;
  logic             slot_end;
  logic             slot_start;
  logic [SEG_W-1:0] seg_cur;
  logic             lit;

  vfd_ctrl_regs u_regs (
    .clk, .rst_n, .mode_wr, .mode_code, .ctrl_wr, .ctrl_code,
    .last_idx, .dim_code, .disp_on, .mode_changed
  );

  vfd_slot_timer #(.SUB_CYC(SUB_CYC)) u_timer (
    .clk, .rst_n, .last_idx, .slot, .sub, .nxt_slot,
    .slot_end, .slot_start, .frame_end
  );

  vfd_seg_fetch u_fetch (
    .clk, .rst_n, .slot_start, .slot_end, .nxt_slot,
    .rd_data(ram_rd_data), .rd_en(ram_rd_en), .rd_addr(ram_rd_addr), .seg_cur
  );

  assign lit      = disp_on && ({1'b0, sub} < dim_width(dim_code));
  assign grid_out = lit ? (16'(1) << slot) : '0;
  assign seg_out  = lit ? seg_cur : '0;

  // R5
  property one_grid;
    @(posedge clk) disable iff (!rst_n) $onehot0(grid_out);
  endproperty
  one_grid_chk: assert property (one_grid);

  // R7
  property dark_when_off;
    @(posedge clk) disable iff (!rst_n) !disp_on |-> (grid_out == '0 && seg_out == '0);
  endproperty
  dark_off_chk: assert property (dark_when_off);

  // R5 R2
  property grid_within_mode;
    @(posedge clk) disable iff (!rst_n)
      (disp_on && !$past(mode_changed)) |-> ((32'(grid_out) >> (32'(last_idx) + 1)) == 0);
  endproperty
  grid_mode_chk: assert property (grid_within_mode);
endmodule

// File: tb/sim_vfd_grid_scanner.sv
module sim_vfd_grid_scanner;
  localparam int SUB = 2;
  localparam int SLOT_CYC = 16 * SUB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [3:0]  mode_code = '0;
  logic        ctrl_wr = 1'b0;
  logic [3:0]  ctrl_code = '0;
  logic        ram_rd_en;
  logic [5:0]  ram_rd_addr;
  logic [7:0]  ram_rd_data;
  logic [15:0] grid_out;
  logic [23:0] seg_out;
  logic        frame_end;

  logic [7:0] mem [48];
  int checks = 0;
  int errors = 0;
  int bad_addr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vfd_grid_scanner #(.SUB_CYC(SUB)) u0 (.*);

  always @(posedge clk) begin
    if (ram_rd_en) begin
      if (ram_rd_addr < 6'd48) ram_rd_data <= mem[ram_rd_addr];
      else begin
        ram_rd_data <= 8'hxx;
        bad_addr++;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_mem(input int seed);
    for (int a = 0; a < 48; a++) mem[a] = 8'((a * 37 + seed * 11 + 5) ^ (a << 3));
  endtask

  function automatic int width_of(input int code);
    return (code < 3) ? (1 << code) : code + 7;
  endfunction

  task automatic wr_mode(input logic [3:0] c);
    @(negedge clk); mode_wr = 1; mode_code = c;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic wr_ctrl(input logic [3:0] c);
    @(negedge clk); ctrl_wr = 1; ctrl_code = c;
    @(negedge clk); ctrl_wr = 0;
  endtask

  task automatic wait_fe();
    do @(negedge clk); while (frame_end !== 1'b1);
  endtask

  // checks one full frame cycle by cycle, after letting one frame settle
  task automatic check_frame(input int digits, input int w, input bit on, input string req);
    int len = digits * SLOT_CYC;
    int gbad = 0, sbad = 0, fbad = 0;
    logic [15:0] ga = '0, ge = '0;
    logic [23:0] sa = '0, se = '0;
    wait_fe(); wait_fe();
    for (int c = 0; c < len; c++) begin
      int sl, sb;
      logic [15:0] eg;
      logic [23:0] es;
      @(negedge clk);
      sl = c / SLOT_CYC;
      sb = (c % SLOT_CYC) / SUB;
      eg = (on && sb < w) ? (16'(1) << sl) : '0;
      es = (on && sb < w) ? {mem[3*sl+2], mem[3*sl+1], mem[3*sl]} : '0;
      if (grid_out !== eg) begin if (gbad == 0) begin ga = grid_out; ge = eg; end gbad++; end
      if (seg_out !== es) begin if (sbad == 0) begin sa = seg_out; se = es; end sbad++; end
      if (frame_end !== (c == len - 1)) fbad++;
    end
    check({req, " grid (R5)"}, 64'(ga), 64'(ge));
    if (gbad != 0 && ga == ge) check({req, " grid count"}, 64'(gbad), 0);
    check({req, " seg (R6)"}, 64'(sa), 64'(se));
    if (sbad != 0 && sa == se) check({req, " seg count"}, 64'(sbad), 0);
    check({req, " frame_end (R8)"}, 64'(fbad), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 grid reset", 64'(grid_out), 0);
    check("R1 seg reset", 64'(seg_out), 0);
    check_frame(16, 1, 0, "R1 dark 16-digit frame");
  endtask

  task automatic t_dim_sweep();
    for (int d = 0; d < 8; d++) begin
      wr_ctrl(4'(8 + d));
      check_frame(16, width_of(d), 1, $sformatf("R4 dim code %0d", d));
    end
  endtask

  task automatic t_mode8();
    load_mem(2);
    wr_mode(4'b0000);
    check("R3 off after mode change", 64'(grid_out | 16'(|seg_out)), 0);
    check_frame(8, 14, 0, "R3 8-digit dark");
    wr_ctrl(4'b1011);
    check_frame(8, 10, 1, "R2 8-digit lit");
    wr_mode(4'b0000);
    check_frame(8, 10, 1, "R3 same mode no effect");
    wr_mode(4'b0101);
    check_frame(8, 10, 1, "R2 invalid code ignored");
  endtask

  task automatic t_mode12();
    load_mem(3);
    wr_mode(4'b1011);
    check_frame(12, 10, 0, "R3 12-digit dark");
    wr_ctrl(4'b1010);
    check_frame(12, 4, 1, "R2 12-digit lit");
    wr_ctrl(4'b0110);
    check_frame(12, 13, 0, "R7 off keeps scanning");
  endtask

  task automatic t_same_cycle();
    wr_ctrl(4'b1001);
    check_frame(12, 2, 1, "R4 relit");
    @(negedge clk); mode_wr = 1; mode_code = 4'b1111; ctrl_wr = 1; ctrl_code = 4'b1111;
    @(negedge clk); mode_wr = 0; ctrl_wr = 0;
    check_frame(16, 14, 0, "R9 mode change wins");
    check("R10 read addresses", 64'(bad_addr), 0);
  endtask

  initial begin
    load_mem(1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_dim_sweep();
    t_mode8();
    t_mode12();
    t_same_cycle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule